// File: doc/BRIEF.md
# Set-Associative Cache Controller with Run-Time Write Policy

This block sits between a CPU load/store port and a word-wide main-memory port. It holds recently used memory blocks in a small set-associative array. A word address has three fields: the word-within-block offset in the low bits, the set index above it, and the tag in the remaining upper bits. The set that a block may occupy is its block address modulo the number of sets. Inside a set, any way may hold the block. When a block must be placed, an invalid way is used first; otherwise the least recently used way is replaced.

The write policy is taken from `wb_mode_i` and latched for each request when the request is accepted.

- **Write-through** (`wb_mode_i`=0): every store goes to main memory. Stores that miss do not allocate a line.
- **Write-back** (`wb_mode_i`=1): stores update only the cached copy and mark the line modified. Stores that miss allocate the line first.

A modified line that is chosen for replacement is copied back word by word before its replacement is fetched. This happens whichever policy is active at that moment. The CPU port accepts one request at a time and stalls while memory traffic is in progress. Two counters record hits and misses, so software can form the hit ratio as hits / (hits + misses).

The default configuration is 2 ways, 4 sets, 4 words per block, 8-bit word addresses and 32-bit data. With `WAYS`=1 the same logic places every block in exactly one line, which is direct mapping.

Top module: `sa_cache`

## Requirements
- R1: Address fields: offset = `req_addr_i[1:0]`, set = `req_addr_i[3:2]` (block address mod 4), tag = `req_addr_i[7:4]`. A read returns the word stored at exactly that address.
- R2: A read miss fetches the whole block as four single-word memory reads. It then returns the requested word. Later reads of any word in that block hit and issue no memory traffic.
- R3: Two blocks with the same set index and different tags are resident at the same time. A third such block replaces the least recently used of the two.
- R4: In write-through mode, a store hit updates both the cached word and main memory before the response.
- R5: In write-through mode, a store miss writes main memory only. It performs no block fetch, and a following read of that address is a miss.
- R6: In write-back mode, a store leaves main memory unchanged and the new value is returned by later reads.
- R7: In write-back mode, a store miss fetches the block (four memory reads), merges the store into it, and later reads of the block hit.
- R8: A modified victim is written to memory as four word writes, all issued before any read of the incoming block. A clean victim causes no memory write.
- R9: Each accepted request adds exactly one to either `hit_cnt_o` or `miss_cnt_o`, chosen by whether the first tag lookup hit.
- R10: `req_ready_o` is high only while idle. A hit responds two cycles after acceptance. `resp_valid_o` is a one-cycle pulse and is followed by ready. The request stays stalled while memory transfers are in progress.
- R11: After reset, both counters are zero, `req_ready_o` is high, `resp_valid_o` and `mem_req_o` are low, and every line is invalid, so the first access misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_mode_i | input | 1 | 1 selects write-back, 0 write-through; sampled when a request is accepted |
| req_valid_i | input | 1 | CPU request present |
| req_we_i | input | 1 | 1 for a store, 0 for a load |
| req_addr_i | input | 8 | Word address |
| req_wdata_i | input | 32 | Store data |
| req_ready_o | output | 1 | Controller idle; request accepted on this edge when valid |
| resp_valid_o | output | 1 | One-cycle response strobe |
| resp_rdata_o | output | 32 | Load data, valid with `resp_valid_o` |
| mem_req_o | output | 1 | Memory transfer request, held until acknowledged |
| mem_we_o | output | 1 | 1 for a memory write, 0 for a read |
| mem_addr_o | output | 8 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | One-cycle completion of the pending memory transfer |
| mem_rdata_i | input | 32 | Memory read data, valid with `mem_ack_i` |
| hit_cnt_o | output | 16 | Number of hits |
| miss_cnt_o | output | 16 | Number of misses |

## Verification
The assertions rely on the memory side following a simple handshake:
- `mem_ack_i` is asserted only while a transfer is pending.
- The acknowledge lasts a single cycle.
- Read data arrives together with the acknowledge.

The memory model in the bench answers each request exactly once, one cycle after it first sees the request. It then deasserts the acknowledge for at least a cycle, so a request is never acknowledged twice. On the CPU side, the bench raises `req_valid_i` only while `req_ready_o` is high. It changes `wb_mode_i` only between requests, because the mode is latched at acceptance.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WRITEBACK,
    ST_REFILL,
    ST_MEMWR,
    ST_RESPOND
  } cache_state_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int WAYS  = 2,
  parameter int SETS  = 4,
  parameter int TAG_W = 4,
  parameter int IDX_W = 2,
  parameter int WAY_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] set_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             touch_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic             fill_i,
  input  logic [WAY_W-1:0] fill_way_i,
  input  logic             dirty_set_i,
  input  logic             dirty_clr_i,
  input  logic [WAY_W-1:0] dirty_way_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o,
  output logic [WAY_W-1:0] vict_way_o,
  output logic             vict_valid_o,
  output logic             vict_dirty_o,
  output logic [TAG_W-1:0] vict_tag_o
);
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAY_W-1:0] age_q   [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic [WAYS-1:0]  match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_q[set_i][w] && (tag_q[set_i][w] == tag_i);
  end

  assign hit_o = |match;

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (match[w]) hit_way_o = WAY_W'(w);
  end

  // Invalid way wins; otherwise the oldest age marks the LRU way
  always_comb begin
    logic found;
    found      = 1'b0;
    vict_way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (!valid_q[set_i][w] && !found) begin
        vict_way_o = WAY_W'(w);
        found      = 1'b1;
      end
    if (!found)
      for (int w = 0; w < WAYS; w++)
        if (age_q[set_i][w] == WAY_W'(WAYS-1)) vict_way_o = WAY_W'(w);
  end

  assign vict_valid_o = valid_q[set_i][vict_way_o];
  assign vict_dirty_o = dirty_q[set_i][vict_way_o];
  assign vict_tag_o   = tag_q[set_i][vict_way_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          age_q[s][w] <= WAY_W'(w);
        end
      end
    end else begin
      if (fill_i) begin
        tag_q[set_i][fill_way_i]   <= tag_i;
        valid_q[set_i][fill_way_i] <= 1'b1;
        dirty_q[set_i][fill_way_i] <= 1'b0;
      end
      if (dirty_set_i) dirty_q[set_i][dirty_way_i] <= 1'b1;
      if (dirty_clr_i) dirty_q[set_i][dirty_way_i] <= 1'b0;
      if (touch_i)
        for (int w = 0; w < WAYS; w++)
          if (WAY_W'(w) == touch_way_i)
            age_q[set_i][w] <= '0;
          else if (age_q[set_i][w] < age_q[set_i][touch_way_i])
            age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
    end
  end

  p_unique_tag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));

  for (genvar s = 0; s < SETS; s++) begin : g_dv
    p_dirty_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dirty_q[s] & ~valid_q[s]) == '0);
  end
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int WAYS   = 2,
  parameter int SETS   = 4,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 2,
  parameter int WAY_W  = 1
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  set_i,
  input  logic [WAY_W-1:0]  way_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] line_q [SETS][WAYS][WORDS];

  assign rdata_o = line_q[set_i][way_i][off_i];

  always_ff @(posedge clk_i)
    if (we_i) line_q[set_i][way_i][off_i] <= wdata_i;
endmodule

// File: rtl/cache_stats.sv
module cache_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             miss_i,
  output logic [CNT_W-1:0] hit_cnt_o,
  output logic [CNT_W-1:0] miss_cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_cnt_o  <= '0;
      miss_cnt_o <= '0;
    end else begin
      if (hit_i)  hit_cnt_o  <= hit_cnt_o + 1'b1;
      if (miss_i) miss_cnt_o <= miss_cnt_o + 1'b1;
    end
  end

  p_single_event_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_i && miss_i));
endmodule

// File: rtl/sa_cache.sv
module sa_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int WAYS   = 2,
  parameter int SETS   = 4,
  parameter int WORDS  = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wb_mode_i,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] resp_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  miss_cnt_o
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  cache_state_e      state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, resp_q, rd_data;
  logic              we_q, mode_q, retry_q;
  logic [OFF_W-1:0]  cnt_q;
  logic [WAY_W-1:0]  way_q, hit_way, vict_way, ds_way, dirty_way;
  logic [TAG_W-1:0]  wb_tag_q, vict_tag;
  logic              hit, vict_valid, vict_dirty;

  logic [OFF_W-1:0] off;
  logic [IDX_W-1:0] set;
  logic [TAG_W-1:0] tag;
  assign off = addr_q[OFF_W-1:0];
  assign set = addr_q[OFF_W +: IDX_W];
  assign tag = addr_q[ADDR_W-1 -: TAG_W];

  logic in_lookup, last_word, ds_we;
  logic [OFF_W-1:0]  ds_off;
  logic [DATA_W-1:0] ds_wdata;
  assign in_lookup = (state_q == ST_LOOKUP);
  assign last_word = (cnt_q == OFF_W'(WORDS-1));

  always_comb begin
    if (state_q == ST_WRITEBACK || state_q == ST_REFILL) begin
      ds_way = way_q;
      ds_off = cnt_q;
    end else begin
      ds_way = hit_way;
      ds_off = off;
    end
    ds_we    = ((state_q == ST_REFILL) && mem_ack_i) || (in_lookup && hit && we_q);
    ds_wdata = (state_q == ST_REFILL) ? mem_rdata_i : wdata_q;
  end

  assign dirty_way = in_lookup ? hit_way : way_q;

  cache_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_tags (
    .clk_i, .rst_ni,
    .set_i        (set),
    .tag_i        (tag),
    .touch_i      (in_lookup && hit),
    .touch_way_i  (hit_way),
    .fill_i       ((state_q == ST_REFILL) && mem_ack_i && last_word),
    .fill_way_i   (way_q),
    .dirty_set_i  (in_lookup && hit && we_q && mode_q),
    .dirty_clr_i  ((state_q == ST_WRITEBACK) && mem_ack_i && last_word),
    .dirty_way_i  (dirty_way),
    .hit_o        (hit),
    .hit_way_o    (hit_way),
    .vict_way_o   (vict_way),
    .vict_valid_o (vict_valid),
    .vict_dirty_o (vict_dirty),
    .vict_tag_o   (vict_tag)
  );

  cache_data_store #(.WAYS(WAYS), .SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W),
                     .IDX_W(IDX_W), .OFF_W(OFF_W), .WAY_W(WAY_W)) u_data (
    .clk_i,
    .set_i   (set),
    .way_i   (ds_way),
    .off_i   (ds_off),
    .we_i    (ds_we),
    .wdata_i (ds_wdata),
    .rdata_o (rd_data)
  );

  cache_stats #(.CNT_W(CNT_W)) u_stats (
    .clk_i, .rst_ni,
    .hit_i      (in_lookup && !retry_q && hit),
    .miss_i     (in_lookup && !retry_q && !hit),
    .hit_cnt_o  (hit_cnt_o),
    .miss_cnt_o (miss_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      resp_q   <= '0;
      we_q     <= 1'b0;
      mode_q   <= 1'b0;
      retry_q  <= 1'b0;
      cnt_q    <= '0;
      way_q    <= '0;
      wb_tag_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q  <= req_addr_i;
          we_q    <= req_we_i;
          wdata_q <= req_wdata_i;
          mode_q  <= wb_mode_i;
          retry_q <= 1'b0;
          state_q <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          cnt_q <= '0;
          if (hit) begin
            resp_q  <= rd_data;
            state_q <= (we_q && !mode_q) ? ST_MEMWR : ST_RESPOND;
          end else if (we_q && !mode_q) begin
            state_q <= ST_MEMWR;  // no allocation on write-through store miss
          end else begin
            way_q    <= vict_way;
            wb_tag_q <= vict_tag;
            state_q  <= (vict_valid && vict_dirty) ? ST_WRITEBACK : ST_REFILL;
          end
        end
        ST_WRITEBACK: if (mem_ack_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (last_word) state_q <= ST_REFILL;
        end
        ST_REFILL: if (mem_ack_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (last_word) begin
            retry_q <= 1'b1;      // replay lookup, now a guaranteed hit
            state_q <= ST_LOOKUP;
          end
        end
        ST_MEMWR:   if (mem_ack_i) state_q <= ST_RESPOND;
        ST_RESPOND: state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = (state_q == ST_WRITEBACK) || (state_q == ST_REFILL) || (state_q == ST_MEMWR);
    mem_we_o    = (state_q != ST_REFILL);
    mem_wdata_o = (state_q == ST_WRITEBACK) ? rd_data : wdata_q;
    unique case (state_q)
      ST_WRITEBACK: mem_addr_o = {wb_tag_q, set, cnt_q};
      ST_REFILL:    mem_addr_o = {tag, set, cnt_q};
      default:      mem_addr_o = addr_q;
    endcase
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign resp_valid_o = (state_q == ST_RESPOND);
  assign resp_rdata_o = resp_q;

  p_mem_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  p_resp_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o && req_ready_o);

  p_wb_store_silent_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_lookup && we_q && mode_q && hit |=> !mem_req_o);

  p_wt_store_to_mem_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_lookup && we_q && !mode_q |=> mem_req_o && mem_we_o && (mem_addr_o == addr_q));
endmodule

// File: tb/sa_cache_tb.sv
`timescale 1ns/1ps
module sa_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wb_mode = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, resp_valid;
  logic [31:0] resp_rdata;
  logic        mem_req, mem_we;
  logic [7:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic [15:0] hit_cnt, miss_cnt;

  always #10 clk = ~clk;

  sa_cache u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wb_mode_i(wb_mode),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_ready_o(req_ready), .resp_valid_o(resp_valid), .resp_rdata_o(resp_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .hit_cnt_o(hit_cnt), .miss_cnt_o(miss_cnt)
  );

  function automatic logic [31:0] init_val(int a);
    return 32'hC0DE_0000 | 32'(a);
  endfunction

  // behavioural main memory: ack one cycle after request, then idle a cycle
  logic [31:0] mem [256];
  bit          op_log [256];
  int          op_n = 0, mem_wr_n = 0, mem_rd_n = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      for (int a = 0; a < 256; a++) mem[a] <= init_val(a);
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      op_log[op_n[7:0]] <= mem_we;
      op_n <= op_n + 1;
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        mem_wr_n <= mem_wr_n + 1;
      end else begin
        mem_rdata <= mem[mem_addr];
        mem_rd_n <= mem_rd_n + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  int n_chk = 0, n_fail = 0, stall_bad = 0;
  logic [31:0] gold [256];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // exp_hit: 1 hit, 0 miss, -1 either
  task automatic access(input bit we, input int a, input logic [31:0] d, input int exp_hit,
                        output logic [31:0] rd, output int lat);
    int h0, m0;
    h0 = int'(hit_cnt);
    m0 = int'(miss_cnt);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = 8'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!resp_valid) begin
      if (req_ready) stall_bad++;
      @(negedge clk);
      lat++;
    end
    rd = resp_rdata;
    if (we) gold[a] = d;
    chk((int'(hit_cnt) - h0) + (int'(miss_cnt) - m0) == 1, "R9 one count per access",
        32'((int'(hit_cnt) - h0) + (int'(miss_cnt) - m0)), 32'd1);
    if (exp_hit >= 0)
      chk((int'(hit_cnt) - h0) == exp_hit, "R9 hit/miss classification",
          32'(int'(hit_cnt) - h0), 32'(exp_hit));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", n_chk);
    report();
  end

  initial begin
    logic [31:0] rd;
    int lat, w0, r0, o0;
    bit order_ok;
    for (int a = 0; a < 256; a++) gold[a] = init_val(a);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(req_ready === 1'b1 && resp_valid === 1'b0 && mem_req === 1'b0, "R11 idle outputs",
        {29'd0, req_ready, resp_valid, mem_req}, 32'd4);
    chk(hit_cnt == 0 && miss_cnt == 0, "R11 counters zero", {hit_cnt, miss_cnt}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R11: first read misses, fetches 4 words
    r0 = mem_rd_n;
    access(0, 8'h00, 0, 0, rd, lat);
    chk(rd == init_val(8'h00), "R2 miss read data", rd, init_val(8'h00));
    chk(mem_rd_n - r0 == 4, "R2 refill word count", 32'(mem_rd_n - r0), 32'd4);
    r0 = mem_rd_n;
    access(0, 8'h03, 0, 1, rd, lat);
    chk(rd == init_val(8'h03), "R1 offset selects word", rd, init_val(8'h03));
    chk(mem_rd_n == r0, "R2 hit issues no memory read", 32'(mem_rd_n - r0), 32'd0);
    chk(lat == 2, "R10 hit latency", 32'(lat), 32'd2);

    // R1/R3: same set different tag, other set
    access(0, 8'h12, 0, 0, rd, lat);
    chk(rd == init_val(8'h12), "R1 tag 1 set 0", rd, init_val(8'h12));
    chk(lat > 2, "R10 miss stalls", 32'(lat), 32'd3);
    access(0, 8'h05, 0, 0, rd, lat);
    chk(rd == init_val(8'h05), "R1 set 1 data", rd, init_val(8'h05));
    access(0, 8'h01, 0, 1, rd, lat);
    access(0, 8'h10, 0, 1, rd, lat);
    chk(rd == init_val(8'h10), "R3 both ways resident", rd, init_val(8'h10));

    // R3 LRU: 0x00 block is least recent
    access(0, 8'h20, 0, 0, rd, lat);
    access(0, 8'h13, 0, 1, rd, lat);
    access(0, 8'h00, 0, 0, rd, lat);
    chk(rd == init_val(8'h00), "R3 LRU victim refetched", rd, init_val(8'h00));
    access(0, 8'h11, 0, 1, rd, lat);

    // R4 write-through hit
    wb_mode = 1'b0;
    w0 = mem_wr_n;
    access(1, 8'h11, 32'h1111_AAAA, 1, rd, lat);
    chk(mem[8'h11] == 32'h1111_AAAA, "R4 memory updated", mem[8'h11], 32'h1111_AAAA);
    chk(mem_wr_n - w0 == 1, "R4 one memory write", 32'(mem_wr_n - w0), 32'd1);
    access(0, 8'h11, 0, 1, rd, lat);
    chk(rd == 32'h1111_AAAA, "R4 cache updated", rd, 32'h1111_AAAA);

    // R5 write-through miss: no allocation
    r0 = mem_rd_n;
    access(1, 8'h35, 32'h3535_5353, 0, rd, lat);
    chk(mem[8'h35] == 32'h3535_5353, "R5 memory written", mem[8'h35], 32'h3535_5353);
    chk(mem_rd_n == r0, "R5 no refill", 32'(mem_rd_n - r0), 32'd0);
    access(0, 8'h35, 0, 0, rd, lat);
    chk(rd == 32'h3535_5353, "R5 later read misses and sees data", rd, 32'h3535_5353);

    // R6 write-back hit
    wb_mode = 1'b1;
    w0 = mem_wr_n;
    access(1, 8'h00, 32'hD1D1_0000, 1, rd, lat);
    chk(mem[8'h00] == init_val(8'h00), "R6 memory unchanged", mem[8'h00], init_val(8'h00));
    chk(mem_wr_n == w0, "R6 no memory write", 32'(mem_wr_n - w0), 32'd0);
    access(0, 8'h00, 0, 1, rd, lat);
    chk(rd == 32'hD1D1_0000, "R6 cached value returned", rd, 32'hD1D1_0000);

    // R7 write-back miss allocates
    r0 = mem_rd_n; w0 = mem_wr_n;
    access(1, 8'h44, 32'h4444_7777, 0, rd, lat);
    chk(mem_rd_n - r0 == 4, "R7 refill on store miss", 32'(mem_rd_n - r0), 32'd4);
    chk(mem[8'h44] == init_val(8'h44) && mem_wr_n == w0, "R7 memory untouched", mem[8'h44], init_val(8'h44));
    access(0, 8'h44, 0, 1, rd, lat);
    chk(rd == 32'h4444_7777, "R7 merged word", rd, 32'h4444_7777);
    access(0, 8'h46, 0, 1, rd, lat);
    chk(rd == init_val(8'h46), "R7 rest of block", rd, init_val(8'h46));

    // R8 clean victim (0x10 block) then dirty victim (0x00 block)
    w0 = mem_wr_n;
    access(0, 8'h50, 0, 0, rd, lat);
    chk(mem_wr_n == w0, "R8 clean victim dropped", 32'(mem_wr_n - w0), 32'd0);
    w0 = mem_wr_n; o0 = op_n;
    access(0, 8'h61, 0, 0, rd, lat);
    chk(mem_wr_n - w0 == 4, "R8 dirty victim written back", 32'(mem_wr_n - w0), 32'd4);
    chk(mem[8'h00] == 32'hD1D1_0000, "R8 modified word in memory", mem[8'h00], 32'hD1D1_0000);
    chk(rd == init_val(8'h61), "R8 new block data", rd, init_val(8'h61));
    order_ok = (op_n - o0 == 8);
    for (int i = 0; i < 8; i++)
      if (op_log[8'(o0 + i)] != (i < 4)) order_ok = 1'b0;
    chk(order_ok, "R8 writes precede refill reads", 32'(op_n - o0), 32'd8);

    // sweeps: write all, read all, per mode
    for (int m = 1; m >= 0; m--) begin
      int bad;
      wb_mode = m[0];
      for (int a = 0; a < 256; a++)
        access(1, a, 32'h5A00_0000 ^ (32'(a) << 8) ^ 32'(a) ^ (32'(m) << 31), -1, rd, lat);
      bad = 0;
      for (int a = 0; a < 256; a++) begin
        access(0, a, 0, -1, rd, lat);
        if (rd != gold[a]) bad++;
      end
      chk(bad == 0, m ? "R6 sweep read-back" : "R4 sweep read-back", 32'(bad), 32'd0);
    end
    begin
      int bad;
      bad = 0;
      for (int a = 0; a < 256; a++) if (mem[a] != gold[a]) bad++;
      chk(bad == 0, "R4 memory matches after write-through sweep", 32'(bad), 32'd0);
    end
    chk(stall_bad == 0, "R10 ready low while busy", 32'(stall_bad), 32'd0);
    report();
  end
endmodule